// File: doc/BRIEF.md
# Relative Branch Target Unit

This unit works out the next program counter for a conditional branch whose offset is a single signed byte. The caller has already decided whether the branch condition holds. It presents that decision together with the 24-bit program counter of the branch, the offset byte and the emulation-mode flag, and pulses a strobe. One clock later the unit returns the new program counter and the number of cycles the branch costs beyond its base timing.

The program counter is split into an upper bank byte and a lower 16-bit offset. All of the arithmetic stays inside the lower 16 bits and wraps around within them. A branch never changes the bank byte. The extra cost for crossing a 256-byte page is charged only while the emulation flag is set.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `res_valid` is 0, `next_pc` is 0 and `extra_cycles` is 0.
- R2: `res_valid` is 1 exactly in the cycle after a cycle in which `req_valid` was 1, and the results in that cycle belong to that request.
- R3: For a request with `cond_taken` = 0, `next_pc` is the bank byte of `pc` followed by (`pc[15:0]` + 2) mod 65536, and `extra_cycles` is 0.
- R4: For a request with `cond_taken` = 1, `next_pc[15:0]` is (`pc[15:0]` + 2 + the offset) mod 65536. The offset is `disp` read as an 8-bit two's-complement value, so bit 7 set makes it negative.
- R5: A taken branch gets `extra_cycles` = 1 when `emu_mode` = 0, or when bits 15:8 of the target equal bits 15:8 of `pc[15:0]` + 2.
- R6: A taken branch gets `extra_cycles` = 2 when `emu_mode` = 1 and bits 15:8 of the target differ from bits 15:8 of `pc[15:0]` + 2.
- R7: `next_pc[23:16]` always equals `pc[23:16]` of its request, including when the low 16 bits wrap past 0xFFFF or below 0x0000.
- R8: In a cycle with `req_valid` = 0, `next_pc` and `extra_cycles` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| pc | input | 24 | Program counter of the branch instruction |
| disp | input | 8 | Signed branch offset |
| cond_taken | input | 1 | Branch condition result from the caller |
| emu_mode | input | 1 | Emulation-mode flag, enables the page-cross cost |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| next_pc | output | 24 | Next program counter |
| extra_cycles | output | 2 | Extra cycles added by the branch |

## Verification
The bench builds the unit with its default parameters: a 16-bit offset, an 8-bit bank, an 8-bit offset byte and 256-byte pages. These values make the interesting edges easy to reach with hand-picked program counters:
- offsets near 0xFFFF that wrap to low values;
- offsets near 0x0000 that wrap backwards through a negative offset;
- forward and backward page crossings;
- the extreme offsets 0x7F and 0x80.

A swept set of program counters and offsets also runs back-to-back strobes. Between requests, idle gaps confirm that the results are held.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam int unsigned OFS_W  = 16;
  localparam int unsigned BANK_W = 8;
  localparam int unsigned DSP_W  = 8;
  localparam int unsigned PAGE_B = 8;
  localparam int unsigned EXTRA_W = 2;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
  } pc_t;
endpackage

// File: rtl/rbu_base_adder.sv
module rbu_base_adder #(
  parameter int unsigned OFS_W = 16,
  parameter int unsigned STEP  = 2
) (
  input  logic [OFS_W-1:0] ofs_in,
  output logic [OFS_W-1:0] base_ofs
);
  localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);
  always_comb base_ofs = ofs_in + STEP_V;
endmodule

// File: rtl/rbu_target_calc.sv
module rbu_target_calc #(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned DSP_W  = 8,
  parameter int unsigned PAGE_B = 8
) (
  input  logic [OFS_W-1:0] base_ofs,
  input  logic [DSP_W-1:0] disp,
  output logic [OFS_W-1:0] tgt_ofs,
  output logic             page_cross
);
  localparam int unsigned EXT_W = OFS_W - DSP_W;
  logic [OFS_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      always_comb disp_ext = {{EXT_W{disp[DSP_W-1]}}, disp};
    end else begin : g_noext
      always_comb disp_ext = disp[OFS_W-1:0];
    end
  endgenerate

  always_comb begin
    tgt_ofs    = base_ofs + disp_ext;
    page_cross = (tgt_ofs[OFS_W-1:PAGE_B] != base_ofs[OFS_W-1:PAGE_B]);
  end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int unsigned P_OFS_W  = OFS_W,
  parameter int unsigned P_BANK_W = BANK_W,
  parameter int unsigned P_DSP_W  = DSP_W,
  parameter int unsigned P_PAGE_B = PAGE_B
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [P_BANK_W+P_OFS_W-1:0] pc,
  input  logic [P_DSP_W-1:0]          disp,
  input  logic                        cond_taken,
  input  logic                        emu_mode,
  output logic                        res_valid,
  output logic [P_BANK_W+P_OFS_W-1:0] next_pc,
  output logic [1:0]                  extra_cycles
);
  localparam int unsigned PC_W = P_BANK_W + P_OFS_W;

  logic [P_OFS_W-1:0] base_ofs, tgt_ofs;
  logic               page_cross;
  logic [P_OFS_W-1:0] sel_ofs;
  logic [1:0]         sel_extra;

  rbu_base_adder #(.OFS_W(P_OFS_W), .STEP(2)) u_base (
    .ofs_in  (pc[P_OFS_W-1:0]),
    .base_ofs(base_ofs)
  );

  rbu_target_calc #(.OFS_W(P_OFS_W), .DSP_W(P_DSP_W), .PAGE_B(P_PAGE_B)) u_tgt (
    .base_ofs  (base_ofs),
    .disp      (disp),
    .tgt_ofs   (tgt_ofs),
    .page_cross(page_cross)
  );

  always_comb begin
    if (cond_taken) begin
      sel_ofs   = tgt_ofs;
      sel_extra = (emu_mode && page_cross) ? 2'd2 : 2'd1;
    end else begin
      sel_ofs   = base_ofs;
      sel_extra = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      next_pc      <= '0;
      extra_cycles <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        next_pc      <= {pc[PC_W-1:P_OFS_W], sel_ofs};
        extra_cycles <= sel_extra;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  p_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cond_taken) |=> (extra_cycles == 2'd0));
  p_taken_cost_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cond_taken && !emu_mode) |=> (extra_cycles == 2'd1));
  p_bank_keep_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (next_pc[PC_W-1:P_OFS_W] == $past(pc[PC_W-1:P_OFS_W])));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(next_pc) && $stable(extra_cycles)));
endmodule

// File: tb/rel_branch_unit_test.sv
module rel_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] pc = '0;
  logic [7:0]  disp = '0;
  logic        cond_taken = 1'b0;
  logic        emu_mode = 1'b0;
  logic        res_valid;
  logic [23:0] next_pc;
  logic [1:0]  extra_cycles;

  int checks = 0;
  int fails  = 0;
  logic [25:0] expq[$];
  logic [23:0] last_pc;
  logic [1:0]  last_ex;
  bit          done = 0;

  always #2 clk = ~clk;

  rel_branch_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .pc(pc), .disp(disp),
    .cond_taken(cond_taken), .emu_mode(emu_mode), .res_valid(res_valid),
    .next_pc(next_pc), .extra_cycles(extra_cycles)
  );

  function automatic logic [25:0] model(input logic [23:0] p, input logic [7:0] d,
                                        input logic t, input logic e);
    logic [15:0] b, g;
    logic [1:0]  x;
    b = p[15:0] + 16'd2;
    g = b + {{8{d[7]}}, d};
    if (!t) return {2'd0, p[23:16], b};
    x = (e && (g[15:8] != b[15:8])) ? 2'd2 : 2'd1;
    return {x, p[23:16], g};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] p, input logic [7:0] d, input logic t,
                      input logic e);
    @(negedge clk);
    req_valid = 1'b1; pc = p; disp = d; cond_taken = t; emu_mode = e;
    expq.push_back(model(p, d, t, e));
    last_pc = model(p, d, t, e)[23:0];
    last_ex = model(p, d, t, e)[25:24];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      pc = pc ^ 24'h5A5A5A; disp = ~disp; cond_taken = ~cond_taken; emu_mode = ~emu_mode;
    end
  endtask

  // Monitor: scoreboard comparison, R2 R3 R4 R5 R6 R7
  initial begin
    @(negedge rst);
    forever begin
      @(posedge clk);
      #1;
      if (res_valid) begin
        if (expq.size() == 0) chk(0, "R2 unexpected result", 32'(res_valid), 32'd0);
        else begin
          logic [25:0] e;
          e = expq.pop_front();
          chk(next_pc[23:16] == e[23:16], "R7 bank", 32'(next_pc[23:16]), 32'(e[23:16]));
          chk(next_pc[15:0] == e[15:0], "R3/R4 target", 32'(next_pc[15:0]), 32'(e[15:0]));
          chk(extra_cycles == e[25:24], "R5/R6 extra", 32'(extra_cycles), 32'(e[25:24]));
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(res_valid == 0 && next_pc == 0 && extra_cycles == 0, "R1 in reset",
        {7'd0, res_valid, next_pc}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(res_valid == 0 && next_pc == 0 && extra_cycles == 0, "R1 after reset",
        {7'd0, res_valid, next_pc}, 32'd0);

    send(24'h123400, 8'h10, 1'b0, 1'b1);   // R3
    send(24'h123400, 8'h10, 1'b1, 1'b0);   // R4 R5
    send(24'h123400, 8'hF0, 1'b1, 1'b1);   // R6 backward cross
    send(24'h123400, 8'hF0, 1'b1, 1'b0);   // R5 cross without emu
    send(24'h1234F0, 8'h20, 1'b1, 1'b1);   // R6 forward cross
    send(24'h123410, 8'h20, 1'b1, 1'b1);   // R5 same page in emu
    send(24'h7FFFFF, 8'h00, 1'b0, 1'b0);   // R7 wrap not taken
    send(24'h7FFFF0, 8'h7F, 1'b1, 1'b1);   // R7 wrap forward
    send(24'hAB0000, 8'h80, 1'b1, 1'b1);   // R4 R7 wrap backward
    idle(1);
    @(posedge clk); #1;
    chk(res_valid == 1'b0, "R2 no strobe", 32'(res_valid), 32'd0);
    idle(3);
    @(posedge clk); #1;
    chk(next_pc == last_pc && extra_cycles == last_ex, "R8 hold",
        {6'd0, extra_cycles, next_pc}, {6'd0, last_ex, last_pc});

    for (int i = 0; i < 64; i++) begin
      send({8'(i * 37), 16'(i * 16'h0A3D + 16'hFF80)}, 8'(i * 29 + 3), 1'(i % 3 != 0), 1'(i[1]));
      if (i % 8 == 7) idle(2);
    end
    idle(3);
    repeat (2) @(posedge clk);
    #1;
    chk(expq.size() == 0, "R2 all results seen", 32'(expq.size()), 32'd0);
    chk(next_pc == last_pc, "R8 final hold", 32'(next_pc), 32'(last_pc));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule